// File: doc/BRIEF.md
# Converter Power-State Wake-Up Guard

This block follows the low-power state of a sampling converter from two level inputs, a light-sleep request and a deep-sleep request. It drives two enables, one for the voltage reference and one for the rest of the converter. It also decides when the converter has settled after waking and may be started again. While the block is powered down or still settling, every start request is refused and recorded in a sticky early-start flag. An accepted start comes out as a qualified start pulse.

Light sleep keeps the reference powered, so waking from it takes only a short delay. Deep sleep turns the reference off as well. Waking from deep sleep with the on-chip reference takes a long delay. With an external reference that stays powered, it takes the short delay. Both delays are given in nanoseconds and turned into clock cycles from a clock-frequency parameter, rounding up. At the 125 MHz default the short delay is 13 cycles and the long delay is 25000 cycles.

Top module: `pwr_wake_guard`

## Requirements
- R1: During and directly after reset, ref_pwr_en_o, core_pwr_en_o, ready_o, conv_go_o and early_err_o are 0. The block leaves reset in the deep-sleep state, with the reference treated as unsettled.
- R2: Deep sleep has priority over light sleep. After any edge that samples stby_i=1, whatever nap_i is, ref_pwr_en_o, core_pwr_en_o and ready_o are 0.
- R3: After an edge that samples nap_i=1 and stby_i=0, ref_pwr_en_o=1, core_pwr_en_o=0 and ready_o=0.
- R4: From light sleep with a settled reference, ready_o rises NAP_CYC edges after the first edge that samples both sleep inputs low. NAP_CYC is ceil(CLK_HZ*NAP_NS/1e9), which is 13 by default.
- R5: From deep sleep (or reset) with ext_ref_i=0, the same delay is STBY_CYC = ceil(CLK_HZ*STBY_NS/1e9), which is 25000 by default.
- R6: With ext_ref_i=1 sampled at the release edge, waking from deep sleep uses NAP_CYC.
- R7: While settling, ref_pwr_en_o=1, core_pwr_en_o=1 and ready_o=0. Whenever ready_o=1, both enables are 1.
- R8: conv_go_o is conv_req_i AND ready_o, with no clock cycle in between. A request while not ready gives no start.
- R9: A request sampled while ready_o=0 sets early_err_o at that edge. The flag stays 1 through sleep and wake-up.
- R10: early_err_o returns to 0 at the edge that samples an accepted start (conv_go_o=1).
- R11: The reference stays unsettled from deep sleep until a wake-up completes. If light sleep interrupts a deep-sleep wake-up, the next wake with ext_ref_i=0 again takes STBY_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nap_i | input | 1 | Light-sleep request, level |
| stby_i | input | 1 | Deep-sleep request, level; wins over nap_i |
| ext_ref_i | input | 1 | 1 = external, always-powered reference |
| conv_req_i | input | 1 | Conversion start request |
| ref_pwr_en_o | output | 1 | Reference power enable |
| core_pwr_en_o | output | 1 | Enable for the remaining converter circuitry |
| ready_o | output | 1 | Settled; starts are accepted |
| conv_go_o | output | 1 | Qualified conversion start |
| early_err_o | output | 1 | Sticky early-start flag |

## Verification
Several properties are checked on every cycle. Deep sleep turns both enables off, and light sleep keeps only the reference on. Ready always implies both enables and a minimum settling run. A start pulse needs both a request and ready. The error flag sets after any refused request and clears after an accepted one. Some behaviour only the bench scenarios can show, because they measure exact wake-up lengths. These are the short and long delays, the external-reference shortcut, the unsettled reference carried across an interrupted wake-up, and the flag surviving a full sleep-and-wake cycle.

// File: rtl/pwr_wake_guard.sv
module pwr_wake_guard #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int NAP_NS   = 100,
  parameter int STBY_NS  = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nap_i,
  input  logic stby_i,
  input  logic ext_ref_i,
  input  logic conv_req_i,
  output logic ref_pwr_en_o,
  output logic core_pwr_en_o,
  output logic ready_o,
  output logic conv_go_o,
  output logic early_err_o
);

  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam longint NAP_L  = (longint'(CLK_HZ) * longint'(NAP_NS)  + NS_PER_S - 1) / NS_PER_S;
  localparam longint STBY_L = (longint'(CLK_HZ) * longint'(STBY_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam int NAP_CYC  = (NAP_L  < 1) ? 1 : int'(NAP_L);
  localparam int STBY_CYC = (STBY_L < 1) ? 1 : int'(STBY_L);
  localparam int MAX_CYC  = (STBY_CYC > NAP_CYC) ? STBY_CYC : NAP_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_RUN, S_NAP, S_STBY, S_WAKE} pstate_t;

  pstate_t        state;
  logic [CW-1:0]  cnt;
  logic           ref_cold;
  logic           err_q;

  assign ref_pwr_en_o  = (state != S_STBY);
  assign core_pwr_en_o = (state == S_RUN) || (state == S_WAKE);
  assign ready_o       = (state == S_RUN);
  assign conv_go_o     = conv_req_i && ready_o;
  assign early_err_o   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (conv_go_o) begin
      err_q <= 1'b0;
    end else if (conv_req_i) begin
      err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_STBY;
      cnt      <= '0;
      ref_cold <= 1'b1;
    end else if (stby_i) begin
      state    <= S_STBY;
      ref_cold <= 1'b1;
    end else if (nap_i) begin
      state <= S_NAP;
    end else begin
      case (state)
        S_NAP, S_STBY: begin
          state <= S_WAKE;
          cnt   <= (ref_cold && !ext_ref_i) ? CW'(STBY_CYC) : CW'(NAP_CYC);
        end
        S_WAKE: begin
          if (cnt <= CW'(1)) begin
            state    <= S_RUN;
            ref_cold <= 1'b0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

endmodule

// File: rtl/pwr_wake_guard_chk.sv
module pwr_wake_guard_chk #(
  parameter int NAP_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic nap_i,
  input logic stby_i,
  input logic conv_req_i,
  input logic ref_pwr_en_o,
  input logic core_pwr_en_o,
  input logic ready_o,
  input logic conv_go_o,
  input logic early_err_o
);

  int settle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_run <= 0;
    else if (core_pwr_en_o && !ready_o) settle_run <= (settle_run < 1_000_000_000) ? settle_run + 1 : settle_run;
    else settle_run <= 0;
  end

  assert_stby_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (!ref_pwr_en_o && !core_pwr_en_o && !ready_o));

  assert_nap_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_i && !stby_i) |=> (ref_pwr_en_o && !core_pwr_en_o));

  assert_min_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (settle_run >= NAP_CYC));

  assert_ready_pwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ref_pwr_en_o && core_pwr_en_o));

  assert_go_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |-> (ready_o && conv_req_i));

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_i && !ready_o) |=> early_err_o);

  assert_err_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |=> !early_err_o);

endmodule

bind pwr_wake_guard pwr_wake_guard_chk #(.NAP_CYC(NAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .nap_i(nap_i), .stby_i(stby_i), .conv_req_i(conv_req_i),
  .ref_pwr_en_o(ref_pwr_en_o), .core_pwr_en_o(core_pwr_en_o), .ready_o(ready_o),
  .conv_go_o(conv_go_o), .early_err_o(early_err_o)
);

// File: tb/pwr_wake_guard_bench.sv
`timescale 1ns/1ps
module pwr_wake_guard_bench;

  localparam longint F_HZ = 125_000_000;
  localparam int EXP_NAP  = int'((F_HZ * 100 + 999_999_999) / 1_000_000_000);
  localparam int EXP_STBY = int'((F_HZ * 200_000 + 999_999_999) / 1_000_000_000);

  // row: {stby, nap, exp_ref, exp_core, exp_ready}
  localparam logic [4:0] TBL [4] = '{5'b00_111, 5'b01_100, 5'b10_000, 5'b11_000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nap = 1'b0, stby = 1'b0, ext = 1'b0, req = 1'b0;
  logic ref_en, core_en, rdy, go, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_wake_guard u_pwr_wake_guard (
    .clk(clk), .rst_n(rst_n), .nap_i(nap), .stby_i(stby), .ext_ref_i(ext), .conv_req_i(req),
    .ref_pwr_en_o(ref_en), .core_pwr_en_o(core_en), .ready_o(rdy),
    .conv_go_o(go), .early_err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sleep inputs must already be low; counts edges from the release edge until ready
  task automatic wake(output int n);
    n = 0;
    do begin
      @(posedge clk); #2; n++;
      if (n == 1) begin
        chk("R7 settling enables", {ref_en, core_en, rdy}, 3'b110);
      end
    end while (!rdy && n < 30000);
  endtask

  initial begin
    int n;
    #(8 * 190_000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {ref_en, core_en, rdy, go, err}, 0);
    rst_n = 1'b1;
    #1 chk("R1 outputs after release", {ref_en, core_en, rdy, go, err}, 0);
    wake(n);
    chk("R5 cold wake after reset", n, EXP_STBY + 1);

    @(negedge clk); nap = 1'b1;
    @(negedge clk); nap = 1'b0;
    wake(n);
    chk("R4 nap wake length", n, EXP_NAP + 1);

    ext = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); {stby, nap} = TBL[i][4:3];
      @(negedge clk);
      chk("R2 R3 table enables", {ref_en, core_en, rdy}, int'(TBL[i][2:0]));
      stby = 1'b0; nap = 1'b0;
      if (TBL[i][4:3] != 2'b00) begin
        wake(n);
        chk("R6 R4 table wake", n, EXP_NAP + 1);
      end
    end

    @(negedge clk); stby = 1'b1;
    @(negedge clk); stby = 1'b0;
    wake(n);
    chk("R6 external ref standby wake", n, EXP_NAP + 1);
    ext = 1'b0;

    @(negedge clk); stby = 1'b1;
    @(negedge clk); stby = 1'b0;
    repeat (100) @(negedge clk);
    nap = 1'b1;
    @(negedge clk);
    chk("R3 nap during cold wake", {ref_en, core_en, rdy}, 3'b100);
    nap = 1'b0;
    wake(n);
    chk("R11 cold reference keeps long delay", n, EXP_STBY + 1);

    @(negedge clk); nap = 1'b1;
    @(negedge clk); req = 1'b1;
    #1 chk("R8 no start while asleep", go, 0);
    @(negedge clk); req = 1'b0;
    chk("R9 early flag set", err, 1);
    nap = 1'b0;
    wake(n);
    chk("R9 flag sticky through wake", err, 1);
    @(negedge clk); req = 1'b1;
    #1 chk("R8 start when ready", go, 1);
    @(negedge clk); req = 1'b0;
    chk("R10 flag cleared by start", err, 0);

    @(negedge clk); nap = 1'b1;
    @(negedge clk); nap = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1;
    #1 chk("R8 no start while settling", go, 0);
    @(negedge clk); req = 1'b0;
    chk("R9 request during settling", err, 1);
    wake(n);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R10 cleared after settle start", err, 0);

    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset mid-run", {ref_en, core_en, rdy, err}, 0);
    @(negedge clk); rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule